// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is an SPI master driven through eight byte-wide host registers. The host first loads an opcode, two low address bytes and up to four data bytes. It then writes a mode byte. The upper nibble of the mode byte picks one of eleven fixed frame shapes. The lower nibble gives bits 19:16 of the flash address.

The mode write starts one complete transaction with chip select held low. During the transaction the engine sends the opcode, then the address bytes if the shape has them, then a dummy byte where the shape needs one, then write data, and then it clocks in read data. Received bytes go back into the data registers, where the host fetches them after the busy flag drops.

Register map (offsets the engine's behaviour depends on):

| Offset | Contents |
|---|---|
| 0 | opcode |
| 1 | mode |
| 2 | address bits 15:8 |
| 3 | address bits 7:0 |
| 4..7 | data bytes, used for both write data and read data |

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, busy is 0 and all eight registers read 0x00.
- R2: While busy is 0, a host write to offset N (0..7) stores the byte, and host_rdata returns it combinationally when host_addr is N. The map is: 0 opcode, 1 mode, 2 address[15:8], 3 address[7:0], 4..7 data.
- R3: A host write to offset 1 whose upper nibble is 1..0xB starts exactly one frame. In the cycle after the write, busy is 1 and spi_cs_n is 0. busy then equals the inverse of spi_cs_n until chip select rises at the end of the frame.
- R4: Every frame begins with the opcode byte. Shapes that carry an address then send three address bytes: {4'h0, mode[3:0]}, offset 2, offset 3. Address bits 23:20 are therefore always zero.
- R5: Frame byte counts by type are as follows. Type 1: opcode only, 1 byte. Type 2: opcode and data[4], 2 bytes. Type 3: opcode and 2 read bytes, 3 bytes. Type 4: opcode and address, 4 bytes. Type 5: address frame plus data[4], 5 bytes. Type 6: address frame plus data[4..7], 8 bytes. Types 8, 9, 0xA and 0xB: address frame plus 1, 2, 3 and 4 read bytes. Write data is sent from offset 4 upward.
- R6: Type 7 sends the address frame, then a dummy byte of 0x00 on MOSI, then reads four bytes (9 bytes in total). The byte received during the dummy slot is not stored anywhere.
- R7: The k-th read byte (k from 0) of a frame is stored at offset 4+k. Data registers above the last read slot keep their earlier values.
- R8: A mode write with upper nibble 0 or 0xC..0xF stores the mode byte but starts no frame: spi_cs_n stays 1 and busy stays 0.
- R9: While busy is 1, host writes to any offset, including the mode register, change no register and start no new frame.
- R10: The bus uses SPI mode 0. spi_sclk and spi_mosi are 0 while spi_cs_n is 1. Bits go MSB first. MOSI does not change while SCLK is high. The SCLK period is CLK_DIV system clocks (CLK_DIV even, at least 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 3 | Register offset for write and read |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register contents at host_addr |
| busy | output | 1 | Transaction in progress |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | Master data out |
| spi_miso | input | 1 | Slave data in |

## Verification
Two functions can act on the same data register in the same cycle: the engine capturing a received byte, and the host writing a new value there. The bench provokes this by issuing host writes to the opcode, mode and data offsets while a four-byte read frame is running. It then judges the outcome by reading back: each targeted register must hold either its pre-loaded value or the byte the slave model returned, and exactly one chip-select fall may have occurred. A slave model clocks out a position-dependent byte pattern, so a mis-ordered capture or a stored dummy byte is caught when the data offsets are read.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    localparam int REG_CNT  = 8;
    localparam int REG_AW   = $clog2(REG_CNT);
    localparam int OFS_OP   = 0;
    localparam int OFS_MODE = 1;
    localparam int OFS_ADH  = 2;
    localparam int OFS_ADL  = 3;
    localparam int OFS_DAT  = 4;

    typedef logic [7:0] byte_t;

    typedef struct packed {
        logic       ok;
        logic       addr;
        logic       dummy;
        logic [2:0] n_wr;
        logic [2:0] n_rd;
    } frame_t;

    typedef enum logic [1:0] {SQ_IDLE, SQ_LOAD, SQ_WAIT, SQ_END} sq_state_e;

    function automatic frame_t frame_decode(input logic [3:0] ty);
        frame_t f;
        f = '0;
        case (ty)
            4'h1: f.ok = 1'b1;
            4'h2: begin f.ok = 1'b1; f.n_wr = 3'd1; end
            4'h3: begin f.ok = 1'b1; f.n_rd = 3'd2; end
            4'h4: begin f.ok = 1'b1; f.addr = 1'b1; end
            4'h5: begin f.ok = 1'b1; f.addr = 1'b1; f.n_wr = 3'd1; end
            4'h6: begin f.ok = 1'b1; f.addr = 1'b1; f.n_wr = 3'd4; end
            4'h7: begin f.ok = 1'b1; f.addr = 1'b1; f.dummy = 1'b1; f.n_rd = 3'd4; end
            4'h8, 4'h9, 4'hA, 4'hB: begin
                f.ok   = 1'b1;
                f.addr = 1'b1;
                f.n_rd = 3'(ty - 4'd7);
            end
            default: f = '0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
    import spi_eng_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      host_we,
    input  logic [REG_AW-1:0]         host_addr,
    input  byte_t                     host_wdata,
    input  logic                      busy,
    input  logic                      cap_we,
    input  logic [1:0]                cap_slot,
    input  byte_t                     cap_data,
    output byte_t                     host_rdata,
    output byte_t [REG_CNT-1:0]       regs,
    output logic                      launch
);
    byte_t [REG_CNT-1:0] regs_q;
    logic                host_ok;
    logic [REG_AW-1:0]   cap_idx;

    assign host_ok = host_we && !busy;
    assign cap_idx = REG_AW'(OFS_DAT) + REG_AW'(cap_slot);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            if (host_ok)
                regs_q[host_addr] <= host_wdata;
            if (cap_we)
                regs_q[cap_idx] <= cap_data;
        end
    end

    assign launch     = host_ok && (host_addr == REG_AW'(OFS_MODE))
                        && frame_decode(host_wdata[7:4]).ok;
    assign host_rdata = regs_q[host_addr];
    assign regs       = regs_q;
endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic          active;
    logic [7:0]    sh_q;
    logic [7:0]    rx_q;
    logic [2:0]    bit_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sh_q   <= '0;
            rx_q   <= '0;
            bit_q  <= '0;
            cnt_q  <= '0;
            sclk   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active <= 1'b1;
                sh_q   <= tx_byte;
                bit_q  <= '0;
                cnt_q  <= '0;
                sclk   <= 1'b0;
            end else if (active) begin
                if (cnt_q == CW'(HALF - 1)) begin
                    cnt_q <= '0;
                    if (!sclk) begin
                        sclk <= 1'b1;
                        rx_q <= {rx_q[6:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bit_q == 3'd7) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 3'd1;
                            sh_q  <= {sh_q[6:0], 1'b0};
                        end
                    end
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end
        end
    end

    assign mosi    = active && sh_q[7];
    assign rx_byte = rx_q;
endmodule

// File: rtl/spi_eng_seq.sv
module spi_eng_seq
    import spi_eng_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                launch,
    input  byte_t [REG_CNT-1:0] regs,
    input  logic                sh_done,
    input  byte_t               sh_rx,
    output logic                sh_start,
    output byte_t               sh_tx,
    output logic                cs_n,
    output logic                busy,
    output logic                cap_we,
    output logic [1:0]          cap_slot,
    output byte_t               cap_data
);
    sq_state_e  state_q;
    logic [3:0] idx_q;
    frame_t     fr;
    byte_t      mode;
    logic [3:0] hdr, last, off, n_wr4;
    byte_t      tx;
    logic       is_rd;
    logic [1:0] slot;

    assign mode  = regs[OFS_MODE];
    assign fr    = frame_decode(mode[7:4]);
    assign n_wr4 = {1'b0, fr.n_wr};
    assign hdr   = 4'd1 + (fr.addr ? 4'd3 : 4'd0) + {3'b0, fr.dummy};
    assign last  = hdr + n_wr4 + {1'b0, fr.n_rd} - 4'd1;
    assign off   = idx_q - hdr;

    always_comb begin
        tx    = 8'h00;
        is_rd = 1'b0;
        slot  = 2'd0;
        if (idx_q == 4'd0) begin
            tx = regs[OFS_OP];
        end else if (fr.addr && idx_q <= 4'd3) begin
            case (idx_q)
                4'd1:    tx = {4'h0, mode[3:0]};
                4'd2:    tx = regs[OFS_ADH];
                default: tx = regs[OFS_ADL];
            endcase
        end else if (idx_q < hdr) begin
            tx = 8'h00;
        end else if (off < n_wr4) begin
            tx = regs[OFS_DAT + int'(off[1:0])];
        end else begin
            is_rd = 1'b1;
            slot  = 2'(off - n_wr4);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            idx_q   <= '0;
            cs_n    <= 1'b1;
        end else begin
            case (state_q)
                SQ_IDLE: if (launch) begin
                    state_q <= SQ_LOAD;
                    idx_q   <= '0;
                    cs_n    <= 1'b0;
                end
                SQ_LOAD: state_q <= SQ_WAIT;
                SQ_WAIT: if (sh_done) begin
                    if (idx_q == last) begin
                        state_q <= SQ_END;
                    end else begin
                        idx_q   <= idx_q + 4'd1;
                        state_q <= SQ_LOAD;
                    end
                end
                default: begin
                    cs_n    <= 1'b1;
                    state_q <= SQ_IDLE;
                end
            endcase
        end
    end

    assign sh_start = (state_q == SQ_LOAD);
    assign sh_tx    = tx;
    assign busy     = (state_q != SQ_IDLE);
    assign cap_we   = (state_q == SQ_WAIT) && sh_done && is_rd;
    assign cap_slot = slot;
    assign cap_data = sh_rx;
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_eng_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  logic [2:0]  host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic        busy,
    output logic        spi_cs_n,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    byte_t [REG_CNT-1:0] regs;
    logic                launch, cap_we, sh_start, sh_done, sclk_raw, mosi_raw;
    logic [1:0]          cap_slot;
    byte_t               cap_data, sh_tx, sh_rx;

    spi_eng_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .busy       (busy),
        .cap_we     (cap_we),
        .cap_slot   (cap_slot),
        .cap_data   (cap_data),
        .host_rdata (host_rdata),
        .regs       (regs),
        .launch     (launch)
    );

    spi_eng_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .launch   (launch),
        .regs     (regs),
        .sh_done  (sh_done),
        .sh_rx    (sh_rx),
        .sh_start (sh_start),
        .sh_tx    (sh_tx),
        .cs_n     (spi_cs_n),
        .busy     (busy),
        .cap_we   (cap_we),
        .cap_slot (cap_slot),
        .cap_data (cap_data)
    );

    spi_eng_shift #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (sh_start),
        .tx_byte (sh_tx),
        .miso    (spi_miso),
        .sclk    (sclk_raw),
        .mosi    (mosi_raw),
        .done    (sh_done),
        .rx_byte (sh_rx)
    );

    assign spi_sclk = sclk_raw && !spi_cs_n;
    assign spi_mosi = mosi_raw && !spi_cs_n;
endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk
    import spi_eng_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       host_we,
    input logic [2:0] host_addr,
    input logic [7:0] host_wdata,
    input logic       busy,
    input logic       spi_cs_n,
    input logic       spi_sclk,
    input logic       spi_mosi
);
    logic mode_wr, type_ok;
    assign mode_wr = host_we && !busy && (host_addr == 3'(OFS_MODE));
    assign type_ok = frame_decode(host_wdata[7:4]).ok;

    p_launch_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && type_ok) |=> (busy && !spi_cs_n));

    p_busy_cs_r3: assert property (@(posedge clk) disable iff (rst)
        busy != spi_cs_n);

    p_invalid_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && !type_ok) |=> (spi_cs_n && !busy));

    p_idle_lines_r10: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> (!spi_sclk && !spi_mosi));

    p_mosi_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));
endmodule

bind spi_cmd_engine spi_eng_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .busy       (busy),
    .spi_cs_n   (spi_cs_n),
    .spi_sclk   (spi_sclk),
    .spi_mosi   (spi_mosi)
);

// File: tb/spi_cmd_engine_tb.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb;
    localparam int CLK_DIV = 4;
    localparam int TCLK    = 4;

    typedef struct packed {
        logic [7:0] mode;
        logic [3:0] len;
        logic [2:0] nrd;
        logic       has_addr;
        logic       dummy;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{8'h10, 4'd1, 3'd0, 1'b0, 1'b0},
        '{8'h20, 4'd2, 3'd0, 1'b0, 1'b0},
        '{8'h30, 4'd3, 3'd2, 1'b0, 1'b0},
        '{8'h4A, 4'd4, 3'd0, 1'b1, 1'b0},
        '{8'h55, 4'd5, 3'd0, 1'b1, 1'b0},
        '{8'h6F, 4'd8, 3'd0, 1'b1, 1'b0},
        '{8'h73, 4'd9, 3'd4, 1'b1, 1'b1},
        '{8'h81, 4'd5, 3'd1, 1'b1, 1'b0},
        '{8'h9C, 4'd6, 3'd2, 1'b1, 1'b0},
        '{8'hA7, 4'd7, 3'd3, 1'b1, 1'b0},
        '{8'hB2, 4'd8, 3'd4, 1'b1, 1'b0}
    };

    logic       clk = 0, rst = 1, host_we = 0, spi_miso = 0;
    logic [2:0] host_addr = 0;
    logic [7:0] host_wdata = 0, host_rdata;
    logic       busy, spi_cs_n, spi_sclk, spi_mosi;

    int n_chk = 0, n_fail = 0, finished = 0;
    int sl_bits = 0, cs_falls = 0, per_bad = 0, idle_clk = 0, cs_sclk_bad = 0;
    time t_last = 0;
    logic [7:0] sl_cur = 0;
    logic [7:0] mosi_b [16];

    spi_cmd_engine #(.CLK_DIV(CLK_DIV)) u_dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    always #(TCLK/2) clk = ~clk;

    function automatic logic [7:0] resp(input int p);
        return 8'(8'hC3 + p * 23);
    endfunction

    always @(negedge spi_cs_n) begin
        logic [7:0] rb;
        sl_bits = 0;
        cs_falls++;
        if (spi_sclk) cs_sclk_bad++;
        rb = resp(0);
        spi_miso = rb[7];
    end

    always @(posedge spi_sclk) begin
        if (spi_cs_n) idle_clk++;
        else begin
            if (sl_bits % 8 != 0 && ($time - t_last) != CLK_DIV * TCLK) per_bad++;
            t_last = $time;
            sl_cur = {sl_cur[6:0], spi_mosi};
            sl_bits++;
            if (sl_bits % 8 == 0 && sl_bits <= 128) mosi_b[sl_bits/8 - 1] = sl_cur;
        end
    end

    always @(negedge spi_sclk) begin
        logic [7:0] rb;
        if (!spi_cs_n) begin
            rb = resp(sl_bits / 8);
            spi_miso = rb[7 - (sl_bits % 8)];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        host_addr = a;
        #1 v = host_rdata;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin
        #(TCLK * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int falls0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 cs_n", {31'b0, spi_cs_n}, 1);
        chk("R1 sclk", {31'b0, spi_sclk}, 0);
        chk("R1 busy", {31'b0, busy}, 0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1 reg zero", {24'b0, v}, 0);
        end

        // R2 write/readback of the non-launching offsets
        for (int a = 0; a < 8; a++) begin
            if (a != 1) begin
                wr(3'(a), 8'(8'h21 + a * 7));
                rd(3'(a), v);
                chk("R2 readback", {24'b0, v}, 32'(8'(8'h21 + a * 7)));
            end
        end

        // R8 invalid types: stored, no frame
        foreach (VECS[i]) begin end
        for (int k = 0; k < 5; k++) begin
            logic [7:0] m;
            m = (k == 0) ? 8'h00 : 8'(8'hC5 + (k - 1) * 16);
            falls0 = cs_falls;
            wr(3'd1, m);
            chk("R8 no busy", {31'b0, busy}, 0);
            repeat (20) @(negedge clk);
            chk("R8 cs stays high", cs_falls - falls0, 0);
            rd(3'd1, v);
            chk("R8 mode stored", {24'b0, v}, {24'b0, m});
        end

        // Table of all eleven frame types: R3 R4 R5 R6 R7 R10
        for (int i = 0; i < 11; i++) begin
            vec_t vc;
            logic [7:0] op, adh, adl;
            logic [7:0] dat [4];
            int hdr, nwr;
            vc  = VECS[i];
            op  = 8'(8'h90 + i);
            adh = 8'(8'h12 + i);
            adl = 8'(8'h34 + i);
            hdr = 1 + (vc.has_addr ? 3 : 0) + (vc.dummy ? 1 : 0);
            nwr = int'(vc.len) - hdr - int'(vc.nrd);
            wr(3'd0, op); wr(3'd2, adh); wr(3'd3, adl);
            for (int k = 0; k < 4; k++) begin
                dat[k] = 8'(8'h60 + k + i * 4);
                wr(3'(4 + k), dat[k]);
            end
            falls0 = cs_falls;
            per_bad = 0;
            wr(3'd1, vc.mode);
            chk("R3 busy after launch", {31'b0, busy}, 1);
            chk("R3 cs low after launch", {31'b0, spi_cs_n}, 0);
            wait_idle();
            @(negedge clk);
            chk("R3 one frame", cs_falls - falls0, 1);
            chk("R3 cs released", {31'b0, spi_cs_n}, 1);
            chk("R5 bit count", sl_bits, 8 * int'(vc.len));
            chk("R4 opcode", {24'b0, mosi_b[0]}, {24'b0, op});
            chk("R10 sclk period", per_bad, 0);
            if (vc.has_addr) begin
                chk("R4 addr hi nibble", {24'b0, mosi_b[1]}, {28'b0, vc.mode[3:0]});
                chk("R4 addr mid", {24'b0, mosi_b[2]}, {24'b0, adh});
                chk("R4 addr low", {24'b0, mosi_b[3]}, {24'b0, adl});
            end
            if (vc.dummy) chk("R6 dummy zero", {24'b0, mosi_b[4]}, 0);
            for (int k = 0; k < nwr; k++)
                chk("R5 write byte", {24'b0, mosi_b[hdr + k]}, {24'b0, dat[k]});
            for (int k = 0; k < 4; k++) begin
                rd(3'(4 + k), v);
                if (k < int'(vc.nrd))
                    chk("R7 read byte", {24'b0, v}, {24'b0, resp(int'(vc.len) - int'(vc.nrd) + k)});
                else
                    chk("R7 untouched", {24'b0, v}, {24'b0, dat[k]});
            end
            if (vc.dummy) begin
                rd(3'd4, v);
                chk("R6 dummy not stored", {31'b0, v == resp(4)}, 0);
            end
            rd(3'd1, v);
            chk("R2 mode readback", {24'b0, v}, {24'b0, vc.mode});
        end

        // R9 writes during busy ignored (collide with read capture)
        wr(3'd0, 8'h5B);
        wr(3'd5, 8'h44);
        falls0 = cs_falls;
        wr(3'd1, 8'hB3);
        wr(3'd0, 8'hEE);
        wr(3'd1, 8'h10);
        wr(3'd6, 8'h99);
        wait_idle();
        repeat (40) @(negedge clk);
        chk("R9 single frame", cs_falls - falls0, 1);
        chk("R9 idle after", {31'b0, busy}, 0);
        rd(3'd0, v); chk("R9 opcode kept", {24'b0, v}, 8'h5B);
        rd(3'd1, v); chk("R9 mode kept", {24'b0, v}, 8'hB3);
        rd(3'd5, v); chk("R9 R7 capture wins", {24'b0, v}, {24'b0, resp(5)});
        rd(3'd6, v); chk("R9 R7 capture wins", {24'b0, v}, {24'b0, resp(6)});

        // R10 idle lines and cs edge
        chk("R10 no sclk while idle", idle_clk, 0);
        chk("R10 sclk low at cs fall", cs_sclk_bad, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule